// File: doc/BRIEF.md
# Dual-Window TDD Frame Timer

The block sequences the receive and transmit control strobes of a half-duplex radio front end. There are six strobes: RX and TX oscillator power, RX and TX RF chain enable, and RX and TX datapath enable. A 24-bit frame counter starts at a programmable start value and counts up to a programmable last count. It then wraps to zero and begins the next frame.

Each strobe has a primary on/off window. It can also have a secondary window, which is used only while the second-window control bit is set. A burst length sets how many frames run before the block stops. A burst length of zero makes the block run until software clears the enable bit. The block records any overlap between the RX and TX oscillator strobes, and separately between the RX and TX RF chain strobes, in sticky status bits. It can also gate the transmit data request and the receive data-valid with the matching datapath strobe.

A sync-role bit makes the instance one of two things:
- a sync source, which starts at once and pulses `sync_out` at count zero;
- a sync receiver, which waits for `sync_in` before its first frame.

The sequencer has four states:
- IDLE: stopped.
- ARMED: enabled, waiting for sync.
- RUN: counting.
- DONE: burst finished, waiting for enable to drop.

It has these transitions:
- IDLE→RUN: enable set in source role.
- IDLE→ARMED: enable set in receiver role.
- ARMED→RUN: `sync_in` is seen.
- RUN→DONE: the last frame of a nonzero burst ends.
- ARMED, RUN or DONE → IDLE: enable is cleared.

Top module: `tdd_frame_timer`

## Requirements
- R1: After reset, all six strobes, `active`, `frame_tick` and `sync_out` are low, and every register reads zero.
- R2: Writes with `cfg_we` high are stored at the rising edge, and `cfg_rdata` returns the addressed register combinationally. The map is as follows.
  - 0x00 control: bit0 enable, bit1 second-window, bit2 RX gate, bit3 TX gate, bit4 sync source.
  - 0x01 burst length, 8 bits.
  - 0x02 start value, 24 bits.
  - 0x03 last count, 24 bits.
  - 0x04 status, read-only: bit0 oscillator overlap, bit1 RF overlap.
  - From 0x08 upward, edge values, 24 bits, at address 0x08 + 4·lane + 2·window + (0 for on, 1 for off). The lane indices are 0 RX oscillator, 1 TX oscillator, 2 RX RF, 3 TX RF, 4 RX datapath, 5 TX datapath.
  - Bits above a field's width read as zero, and writes to status have no effect.
- R3: In RUN, the counter starts at the start value and steps by one each cycle. After the last count it goes to zero. `frame_tick` is high exactly in the cycles whose count equals the last count, and `active` is high exactly in RUN.
- R4: A strobe rises in the cycle after the count equals its on value and falls in the cycle after the count equals its off value. A window whose on value lies above its off value spans the frame wrap.
- R5: Secondary windows act only while the second-window bit is set.
- R6: A window with equal on and off values never changes its strobe. If one window's on and another's off hit the same count, the on wins, so back-to-back windows stay high continuously.
- R7: A nonzero burst length N runs exactly N frames, the first from the start value, then enters DONE with every strobe low while enable stays set. Only clearing and then setting enable starts it again.
- R8: A burst length of zero keeps frames running without end.
- R9: Whenever `active` is low all strobes are low. After a write that clears enable, `active` is low from the second rising edge after that write on.
- R10: An overlap status bit is set one cycle after its RX and TX strobes are high together. It stays set until the block next leaves IDLE, at which point it clears.
- R11: With the TX gate bit set, `tx_req_out` equals `tx_req_in` AND the TX datapath strobe; otherwise it equals `tx_req_in`. RX gating works the same way for `rx_valid_out`, `rx_valid_in` and the RX datapath strobe.
- R12: In source role, RUN begins one edge after enable is stored, and `sync_out` is high in the RUN cycles whose count is zero. In receiver role, the block stays inactive until `sync_in` is sampled high, `active` rises one edge later at the start value, and `sync_out` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data |
| sync_in | input | 1 | Frame sync from the source instance |
| sync_out | output | 1 | Frame sync pulse when this instance is source |
| frame_tick | output | 1 | High in the last-count cycle of each frame |
| active | output | 1 | Sequencer is in RUN |
| rx_vco_en | output | 1 | RX oscillator power strobe |
| tx_vco_en | output | 1 | TX oscillator power strobe |
| rx_rf_en | output | 1 | RX RF chain strobe |
| tx_rf_en | output | 1 | TX RF chain strobe |
| rx_dp_en | output | 1 | RX datapath strobe |
| tx_dp_en | output | 1 | TX datapath strobe |
| tx_req_in | input | 1 | Upstream transmit data request |
| tx_req_out | output | 1 | Gated transmit data request |
| rx_valid_in | input | 1 | Upstream receive data valid |
| rx_valid_out | output | 1 | Gated receive data valid |

## Verification
- Strobes and overlap status are due one cycle after the count that causes them.
- `active` follows a stored enable by one edge in source role, and follows a sampled `sync_in` by one edge in receiver role.
- Gated request and valid outputs are combinational and due in the same cycle.
- The bench drives every input on the falling edge and checks each output at the next falling edge against an expected count that it advances once per cycle from the requirements. This places every comparison half a cycle after the edge that made the value.

// File: rtl/tdd_timer_pkg.sv
package tdd_timer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_t;

    localparam int unsigned NUM_LANES = 6;
    localparam int unsigned NUM_WIN   = 2;

    localparam int unsigned LANE_RX_VCO = 0;
    localparam int unsigned LANE_TX_VCO = 1;
    localparam int unsigned LANE_RX_RF  = 2;
    localparam int unsigned LANE_TX_RF  = 3;
    localparam int unsigned LANE_RX_DP  = 4;
    localparam int unsigned LANE_TX_DP  = 5;

    localparam int unsigned A_CTRL      = 0;
    localparam int unsigned A_BURST     = 1;
    localparam int unsigned A_INIT      = 2;
    localparam int unsigned A_LAST      = 3;
    localparam int unsigned A_STAT      = 4;
    localparam int unsigned A_EDGE_BASE = 8;

    localparam int unsigned CTRL_EN     = 0;
    localparam int unsigned CTRL_WIN2   = 1;
    localparam int unsigned CTRL_RXGATE = 2;
    localparam int unsigned CTRL_TXGATE = 3;
    localparam int unsigned CTRL_SRC    = 4;
    localparam int unsigned CTRL_W      = 5;

endpackage

// File: rtl/tdd_cfg_regs.sv
module tdd_cfg_regs
    import tdd_timer_pkg::*;
#(
    parameter int unsigned CNT_W   = 24,
    parameter int unsigned BURST_W = 8,
    parameter int unsigned ADDR_W  = 6,
    parameter int unsigned DATA_W  = 32
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          we,
    input  logic [ADDR_W-1:0]                             addr,
    input  logic [DATA_W-1:0]                             wdata,
    output logic [DATA_W-1:0]                             rdata,
    input  logic [1:0]                                    status,
    output logic                                          run_en,
    output logic                                          win2_en,
    output logic                                          rx_gate,
    output logic                                          tx_gate,
    output logic                                          sync_src,
    output logic [BURST_W-1:0]                            burst_len,
    output logic [CNT_W-1:0]                              cnt_init,
    output logic [CNT_W-1:0]                              cnt_last,
    output logic [NUM_LANES-1:0][NUM_WIN-1:0][CNT_W-1:0]  on_at,
    output logic [NUM_LANES-1:0][NUM_WIN-1:0][CNT_W-1:0]  off_at
);
    localparam int unsigned NUM_EDGE = NUM_LANES * NUM_WIN * 2;

    logic [CTRL_W-1:0]                 ctrl_q;
    logic [BURST_W-1:0]                burst_q;
    logic [CNT_W-1:0]                  init_q;
    logic [CNT_W-1:0]                  last_q;
    logic [NUM_EDGE-1:0][CNT_W-1:0]    edge_q;
    logic                              unused_wdata;

    assign unused_wdata = ^wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            burst_q <= '0;
            init_q  <= '0;
            last_q  <= '0;
            edge_q  <= '0;
        end else if (we) begin
            if (addr == ADDR_W'(A_CTRL))  ctrl_q  <= wdata[CTRL_W-1:0];
            if (addr == ADDR_W'(A_BURST)) burst_q <= wdata[BURST_W-1:0];
            if (addr == ADDR_W'(A_INIT))  init_q  <= wdata[CNT_W-1:0];
            if (addr == ADDR_W'(A_LAST))  last_q  <= wdata[CNT_W-1:0];
            for (int unsigned e = 0; e < NUM_EDGE; e++) begin
                if (addr == ADDR_W'(A_EDGE_BASE + e)) edge_q[e] <= wdata[CNT_W-1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(A_CTRL))  rdata = DATA_W'(ctrl_q);
        if (addr == ADDR_W'(A_BURST)) rdata = DATA_W'(burst_q);
        if (addr == ADDR_W'(A_INIT))  rdata = DATA_W'(init_q);
        if (addr == ADDR_W'(A_LAST))  rdata = DATA_W'(last_q);
        if (addr == ADDR_W'(A_STAT))  rdata = DATA_W'(status);
        for (int unsigned e = 0; e < NUM_EDGE; e++) begin
            if (addr == ADDR_W'(A_EDGE_BASE + e)) rdata = DATA_W'(edge_q[e]);
        end
    end

    // edge slot order: (lane * NUM_WIN + window) * 2 + {0:on, 1:off}
    for (genvar s = 0; s < NUM_LANES; s++) begin : g_lane
        for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
            assign on_at[s][w]  = edge_q[(s * NUM_WIN + w) * 2];
            assign off_at[s][w] = edge_q[(s * NUM_WIN + w) * 2 + 1];
        end
    end

    assign run_en    = ctrl_q[CTRL_EN];
    assign win2_en   = ctrl_q[CTRL_WIN2];
    assign rx_gate   = ctrl_q[CTRL_RXGATE];
    assign tx_gate   = ctrl_q[CTRL_TXGATE];
    assign sync_src  = ctrl_q[CTRL_SRC];
    assign burst_len = burst_q;
    assign cnt_init  = init_q;
    assign cnt_last  = last_q;

endmodule

// File: rtl/tdd_frame_seq.sv
module tdd_frame_seq
    import tdd_timer_pkg::*;
#(
    parameter int unsigned CNT_W   = 24,
    parameter int unsigned BURST_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_en,
    input  logic               sync_src,
    input  logic               sync_in,
    input  logic [BURST_W-1:0] burst_len,
    input  logic [CNT_W-1:0]   cnt_init,
    input  logic [CNT_W-1:0]   cnt_last,
    output logic [CNT_W-1:0]   cnt,
    output logic               active,
    output logic               frame_tick,
    output logic               arm,
    output logic               done
);
    seq_state_t         state_q, state_d;
    logic [CNT_W-1:0]   cnt_q;
    logic [BURST_W-1:0] frm_q;
    logic               load, wrap, at_end, last_frame;

    assign at_end     = (cnt_q == cnt_last);
    assign last_frame = (burst_len != '0) && (frm_q == burst_len - BURST_W'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and control outputs
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        wrap    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (run_en) begin
                    if (sync_src) begin
                        state_d = ST_RUN;
                        load    = 1'b1;
                    end else begin
                        state_d = ST_ARMED;
                    end
                end
            end
            ST_ARMED: begin
                if (!run_en) begin
                    state_d = ST_IDLE;
                end else if (sync_in) begin
                    state_d = ST_RUN;
                    load    = 1'b1;
                end
            end
            ST_RUN: begin
                if (!run_en) begin
                    state_d = ST_IDLE;
                end else if (at_end) begin
                    if (last_frame) state_d = ST_DONE;
                    else            wrap    = 1'b1;
                end
            end
            ST_DONE: begin
                if (!run_en) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            frm_q <= '0;
        end else if (load) begin
            cnt_q <= cnt_init;
            frm_q <= '0;
        end else if (wrap) begin
            cnt_q <= '0;
            frm_q <= frm_q + BURST_W'(1);
        end else if (state_q == ST_RUN && run_en) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign cnt        = cnt_q;
    assign active     = (state_q == ST_RUN);
    assign frame_tick = active && at_end;
    assign arm        = (state_q == ST_IDLE) && run_en;
    assign done       = (state_q == ST_DONE);

endmodule

// File: rtl/tdd_edge_lane.sv
module tdd_edge_lane #(
    parameter int unsigned CNT_W   = 24,
    parameter int unsigned NUM_WIN = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cnt_valid,
    input  logic [CNT_W-1:0]                cnt,
    input  logic [NUM_WIN-1:0]              win_en,
    input  logic [NUM_WIN-1:0][CNT_W-1:0]   on_at,
    input  logic [NUM_WIN-1:0][CNT_W-1:0]   off_at,
    output logic                            level
);
    logic [NUM_WIN-1:0] hit_on, hit_off;
    logic               level_q;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        logic live;
        assign live       = win_en[w] && (on_at[w] != off_at[w]);
        assign hit_on[w]  = live && (cnt == on_at[w]);
        assign hit_off[w] = live && (cnt == off_at[w]);
    end

    // an on-hit outranks an off-hit so abutting windows merge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          level_q <= 1'b0;
        else if (!cnt_valid) level_q <= 1'b0;
        else if (|hit_on)    level_q <= 1'b1;
        else if (|hit_off)   level_q <= 1'b0;
    end

    assign level = level_q;

endmodule

// File: rtl/tdd_frame_timer.sv
module tdd_frame_timer
    import tdd_timer_pkg::*;
#(
    parameter int unsigned CNT_W   = 24,
    parameter int unsigned BURST_W = 8,
    parameter int unsigned ADDR_W  = 6,
    parameter int unsigned DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              sync_in,
    output logic              sync_out,
    output logic              frame_tick,
    output logic              active,
    output logic              rx_vco_en,
    output logic              tx_vco_en,
    output logic              rx_rf_en,
    output logic              tx_rf_en,
    output logic              rx_dp_en,
    output logic              tx_dp_en,
    input  logic              tx_req_in,
    output logic              tx_req_out,
    input  logic              rx_valid_in,
    output logic              rx_valid_out
);
    logic                                          run_en, win2_en, rx_gate, tx_gate, sync_src;
    logic [BURST_W-1:0]                            burst_len;
    logic [CNT_W-1:0]                              cnt_init, cnt_last, cnt;
    logic [NUM_LANES-1:0][NUM_WIN-1:0][CNT_W-1:0]  on_at, off_at;
    logic [NUM_WIN-1:0]                            win_en;
    logic [NUM_LANES-1:0]                          lane_q, lane_out;
    logic [1:0]                                    clash_q;
    logic                                          seq_arm, seq_done;

    tdd_cfg_regs #(
        .CNT_W(CNT_W), .BURST_W(BURST_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .rdata(cfg_rdata), .status(clash_q), .run_en(run_en), .win2_en(win2_en),
        .rx_gate(rx_gate), .tx_gate(tx_gate), .sync_src(sync_src),
        .burst_len(burst_len), .cnt_init(cnt_init), .cnt_last(cnt_last),
        .on_at(on_at), .off_at(off_at)
    );

    tdd_frame_seq #(.CNT_W(CNT_W), .BURST_W(BURST_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .sync_src(sync_src),
        .sync_in(sync_in), .burst_len(burst_len), .cnt_init(cnt_init),
        .cnt_last(cnt_last), .cnt(cnt), .active(active), .frame_tick(frame_tick),
        .arm(seq_arm), .done(seq_done)
    );

    assign win_en[0] = 1'b1;
    for (genvar w = 1; w < NUM_WIN; w++) begin : g_win_en
        assign win_en[w] = win2_en;
    end

    for (genvar s = 0; s < NUM_LANES; s++) begin : g_lane
        tdd_edge_lane #(.CNT_W(CNT_W), .NUM_WIN(NUM_WIN)) u_lane (
            .clk(clk), .rst_n(rst_n), .cnt_valid(active), .cnt(cnt),
            .win_en(win_en), .on_at(on_at[s]), .off_at(off_at[s]),
            .level(lane_q[s])
        );
    end

    assign lane_out = active ? lane_q : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       clash_q <= '0;
        else if (seq_arm) clash_q <= '0;
        else              clash_q <= clash_q |
                              {lane_out[LANE_RX_RF]  & lane_out[LANE_TX_RF],
                               lane_out[LANE_RX_VCO] & lane_out[LANE_TX_VCO]};
    end

    assign rx_vco_en    = lane_out[LANE_RX_VCO];
    assign tx_vco_en    = lane_out[LANE_TX_VCO];
    assign rx_rf_en     = lane_out[LANE_RX_RF];
    assign tx_rf_en     = lane_out[LANE_TX_RF];
    assign rx_dp_en     = lane_out[LANE_RX_DP];
    assign tx_dp_en     = lane_out[LANE_TX_DP];
    assign sync_out     = active && sync_src && (cnt == '0);
    assign tx_req_out   = tx_req_in   & (~tx_gate | lane_out[LANE_TX_DP]);
    assign rx_valid_out = rx_valid_in & (~rx_gate | lane_out[LANE_RX_DP]);

endmodule

// File: rtl/tdd_frame_timer_chk.sv
module tdd_frame_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       active,
    input logic [5:0] lanes,
    input logic       frame_tick,
    input logic       sync_out,
    input logic       sync_src,
    input logic       run_en,
    input logic       arm,
    input logic       done,
    input logic [1:0] clash,
    input logic       tx_gate,
    input logic       tx_req_in,
    input logic       tx_req_out,
    input logic       rx_valid_in,
    input logic       rx_valid_out
);
    // R9
    idle_lanes_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (lanes == 6'b0));

    // R9
    stop_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !run_en) |=> !active);

    // R7
    done_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && run_en) |=> !active);

    // R3
    tick_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick |-> active);

    // R12
    sync_src_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_out |-> (sync_src && active));

    // R10
    vco_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clash[0] && !arm) |=> clash[0]);

    // R10
    vco_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lanes[0] && lanes[1]) |=> clash[0]);

    // R10
    rf_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lanes[2] && lanes[3]) |=> clash[1]);

    // R11
    tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_gate && !lanes[5]) |-> !tx_req_out);

    // R11
    tx_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req_out |-> tx_req_in);

    // R11
    rx_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_out |-> rx_valid_in);

endmodule

bind tdd_frame_timer tdd_frame_timer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .active(active), .lanes(lane_out),
    .frame_tick(frame_tick), .sync_out(sync_out), .sync_src(sync_src),
    .run_en(run_en), .arm(seq_arm), .done(seq_done), .clash(clash_q),
    .tx_gate(tx_gate), .tx_req_in(tx_req_in), .tx_req_out(tx_req_out),
    .rx_valid_in(rx_valid_in), .rx_valid_out(rx_valid_out)
);

// File: tb/tdd_frame_timer_bench.sv
module tdd_frame_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        sync_in = 1'b0;
    logic        sync_out, frame_tick, active;
    logic        rx_vco_en, tx_vco_en, rx_rf_en, tx_rf_en, rx_dp_en, tx_dp_en;
    logic        tx_req_in = 1'b1, tx_req_out, rx_valid_in = 1'b1, rx_valid_out;
    logic [5:0]  lanes;

    int n_chk = 0;
    int n_bad = 0;

    // bench copy of the programmed configuration
    int b_on [6][2];
    int b_off[6][2];
    int b_init = 0, b_last = 0, b_burst = 0;
    bit b_en = 0, b_win2 = 0, b_rxg = 0, b_txg = 0, b_src = 0;

    // expected sequencing: 0 stopped, 1 running, 2 burst finished
    int       m_st = 0, m_cnt = 0, m_frm = 0;
    bit [5:0] m_lvl = '0;

    always #5 clk = ~clk;

    tdd_frame_timer u_tdd_frame_timer (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .sync_in(sync_in),
        .sync_out(sync_out), .frame_tick(frame_tick), .active(active),
        .rx_vco_en(rx_vco_en), .tx_vco_en(tx_vco_en), .rx_rf_en(rx_rf_en),
        .tx_rf_en(tx_rf_en), .rx_dp_en(rx_dp_en), .tx_dp_en(tx_dp_en),
        .tx_req_in(tx_req_in), .tx_req_out(tx_req_out),
        .rx_valid_in(rx_valid_in), .rx_valid_out(rx_valid_out)
    );

    assign lanes = {tx_dp_en, rx_dp_en, tx_rf_en, rx_rf_en, tx_vco_en, rx_vco_en};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = 6'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        cfg_addr = 6'(a);
        #1;
        d = cfg_rdata;
    endtask

    task automatic set_edge(input int s, input int w, input int on, input int off);
        wr(8 + 4 * s + 2 * w, 32'(on));
        wr(8 + 4 * s + 2 * w + 1, 32'(off));
        b_on[s][w] = on; b_off[s][w] = off;
    endtask

    task automatic set_ctrl(input bit en, input bit w2, input bit rg, input bit tg, input bit src);
        b_en = en; b_win2 = w2; b_rxg = rg; b_txg = tg; b_src = src;
        wr(0, {27'b0, src, tg, rg, w2, en});
        m_st = 0; m_lvl = '0;
    endtask

    // move the expected state across one rising edge
    task automatic advance;
        bit [5:0] nxt;
        bit hon, hoff;
        if (m_st == 1) begin
            for (int s = 0; s < 6; s++) begin
                hon = 0; hoff = 0;
                for (int w = 0; w < 2; w++) begin
                    if ((w == 0 || b_win2) && b_on[s][w] != b_off[s][w]) begin
                        if (m_cnt == b_on[s][w])  hon  = 1;
                        if (m_cnt == b_off[s][w]) hoff = 1;
                    end
                end
                nxt[s] = hon ? 1'b1 : (hoff ? 1'b0 : m_lvl[s]);
            end
            m_lvl = nxt;
            if (m_cnt == b_last) begin
                if (b_burst != 0 && m_frm == b_burst - 1) m_st = 2;
                else begin m_cnt = 0; m_frm++; end
            end else begin
                m_cnt++;
            end
        end else begin
            m_lvl = '0;
            if (m_st == 0 && b_en && b_src) begin
                m_st = 1; m_cnt = b_init; m_frm = 0;
            end
        end
    endtask

    // check every output each cycle against the expected state
    task automatic track(input int n, input string lane_tag);
        logic [5:0] el;
        for (int k = 0; k < n; k++) begin
            tx_req_in   = (k % 3 != 0);
            rx_valid_in = (k % 4 != 1);
            #1;
            el = (m_st == 1) ? m_lvl : 6'b0;
            chk(lane_tag, 32'(lanes), 32'(el));
            chk("R3 active", 32'(active), 32'(m_st == 1));
            chk("R3 frame_tick", 32'(frame_tick), 32'(m_st == 1 && m_cnt == b_last));
            chk("R12 sync_out", 32'(sync_out), 32'(m_st == 1 && b_src && m_cnt == 0));
            chk("R11 tx gating", 32'(tx_req_out), 32'(tx_req_in & (!b_txg | el[5])));
            chk("R11 rx gating", 32'(rx_valid_out), 32'(rx_valid_in & (!b_rxg | el[4])));
            advance();
            @(negedge clk);
        end
        tx_req_in = 1'b1; rx_valid_in = 1'b1;
    endtask

    task automatic stop_and_check;
        set_ctrl(0, b_win2, b_rxg, b_txg, b_src);
        @(negedge clk);
        chk("R9 active after clear", 32'(active), 32'd0);
        chk("R9 lanes after clear", 32'(lanes), 32'd0);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R1 lanes", 32'(lanes), 32'd0);
        chk("R1 active", 32'(active), 32'd0);
        chk("R1 frame_tick", 32'(frame_tick), 32'd0);
        chk("R1 sync_out", 32'(sync_out), 32'd0);
        rd(0, d);  chk("R1 ctrl", d, 32'd0);
        rd(3, d);  chk("R1 last", d, 32'd0);
        rd(4, d);  chk("R1 status", d, 32'd0);
        rd(31, d); chk("R1 edge", d, 32'd0);
    endtask

    task automatic t_regs;
        logic [31:0] d;
        wr(3, 32'hFFFF_FFFF); rd(3, d); chk("R2 last width", d, 32'h00FF_FFFF);
        wr(1, 32'h0000_01FF); rd(1, d); chk("R2 burst width", d, 32'h0000_00FF);
        wr(4, 32'h0000_0003); rd(4, d); chk("R2 status read-only", d, 32'd0);
        wr(21, 32'h00AB_CDEF); rd(21, d); chk("R2 edge slot", d, 32'h00AB_CDEF);
        wr(1, 0); b_burst = 0;
        wr(2, 0); b_init = 0;
        wr(3, 9); b_last = 9;
        rd(3, d); chk("R2 last", d, 32'd9);
    endtask

    task automatic t_lanes_setup;
        set_edge(0, 0, 2, 5); set_edge(0, 1, 7, 8);
        set_edge(1, 0, 6, 8); set_edge(1, 1, 3, 3);
        set_edge(2, 0, 1, 4); set_edge(2, 1, 4, 7);
        set_edge(3, 0, 8, 9); set_edge(3, 1, 0, 0);
        set_edge(4, 0, 3, 6); set_edge(4, 1, 0, 1);
        set_edge(5, 0, 5, 9); set_edge(5, 1, 8, 2);
    endtask

    task automatic t_primary;
        logic [31:0] d;
        set_ctrl(1, 0, 0, 0, 1);
        track(34, "R4 R5 primary lanes");
        chk("R8 still running after 3 frames", 32'(active), 32'd1);
        stop_and_check();
        rd(4, d); chk("R10 no overlap", d, 32'd0);
    endtask

    task automatic t_secondary;
        logic [31:0] d;
        set_ctrl(1, 1, 0, 0, 1);
        track(24, "R5 R6 dual lanes");
        stop_and_check();
        rd(4, d); chk("R10 oscillator overlap", d, 32'd1);
        repeat (3) @(negedge clk);
        rd(4, d); chk("R10 sticky while stopped", d, 32'd1);
    endtask

    task automatic t_gated;
        logic [31:0] d;
        set_ctrl(1, 0, 1, 1, 1);
        track(1, "R11 lanes");
        rd(4, d); chk("R10 cleared on restart", d, 32'd0);
        track(24, "R11 lanes");
        stop_and_check();
    endtask

    task automatic t_burst;
        wr(2, 2); b_init = 2;
        wr(3, 4); b_last = 4;
        wr(1, 2); b_burst = 2;
        set_ctrl(1, 0, 0, 0, 1);
        track(14, "R7 burst lanes");
        chk("R7 stopped after burst", 32'(active), 32'd0);
        set_ctrl(0, 0, 0, 0, 1);
        set_ctrl(1, 0, 0, 0, 1);
        track(4, "R7 restart lanes");
        chk("R7 running after restart", 32'(active), 32'd1);
        stop_and_check();
        wr(1, 0); b_burst = 0;
        wr(2, 0); b_init = 0;
        wr(3, 9); b_last = 9;
    endtask

    task automatic t_receiver;
        set_ctrl(1, 0, 0, 0, 0);
        track(5, "R12 armed lanes");
        chk("R12 waits for sync", 32'(active), 32'd0);
        sync_in = 1'b1;
        @(negedge clk);
        sync_in = 1'b0;
        m_st = 1; m_cnt = b_init; m_frm = 0; m_lvl = '0;
        chk("R12 runs after sync", 32'(active), 32'd1);
        track(14, "R12 receiver lanes");
        stop_and_check();
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_lanes_setup();
        t_primary();
        t_secondary();
        t_gated();
        t_burst();
        t_receiver();
        summary();
        $finish;
    end

endmodule